// File: doc/BRIEF.md
# External Interrupt Request Hold and Clear Unit

This unit collects interrupt requests from eight individual request lines and from two encoded-level groups of four wires each. It keeps each request pending until software removes it according to rules that depend on how the request was detected. Each individual line is configured for edge or level sensing. A single global mode bit selects between holding level-type requests in state and passing them straight through from the live inputs. Every input goes through a two-flop synchroniser before detection.

Edge requests are removed by a two-step handshake. Software first reads the pending register and sees the bit as 1, then writes 0 to that bit. Held level requests and group requests are removed by writing 1 to the matching mask bit. Writes to the priority fields and to the per-level group mask never remove a request.

Each individual line runs its own state machine with three named states:

- `ST_IDLE` means nothing is pending.
- `ST_HELD` means a request is pending.
- `ST_ARMED` means a request is pending and was read as 1.

The transitions are:

- set: `ST_IDLE` to `ST_HELD`, on an edge or on an unmasked level.
- arm: `ST_HELD` to `ST_ARMED`, on a read of the pending register.
- release: `ST_ARMED` to `ST_IDLE`, on a write of 0 with no new edge.
- re-hold: `ST_ARMED` to `ST_HELD`, on a write of 1 or on a write of 0 that meets a new edge.
- mask-clear: `ST_HELD` or `ST_ARMED` to `ST_IDLE`, for a level line on a mask-set write or when the global mode is 1.

Each group uses the same `ST_IDLE` and `ST_HELD` states with set and mask-clear transitions only.

Top module: `irq_hold_ctl`

## Requirements
- R1: After reset the pending register, the group pending register and all outputs read 0. The line mask reads 0xFF, the group mask reads 0x03, and the sense and mode registers read 0.
- R2: When a line's sense bit is 1 (edge), a rising edge on its pin sets its pending bit. A high pulse lasting four or more clocks is detected.
- R3: An edge request clears only when a write of 0 to its bit of the pending register (select 0) follows a read of the pending register that returned that bit as 1. A write of 0 with no such read leaves the bit set. A write of 1 leaves it set.
- R4: Writing 1 to an edge line's bit through the mask-set register (select 1) leaves its pending bit set.
- R5: When mode is 0 and a line's sense bit is 0 (level), a high, unmasked pin sets a held request. The request stays after the pin falls and ignores pending-register writes. It clears when 1 is written to its bit through mask-set.
- R6: Writes to the priority registers (select 5 holds lines 3..0 and select 6 holds lines 7..4, 2 bits per line, line 0 in bits 1:0) leave a held level request set.
- R7: When mode is 0, a group whose synchronised 4-bit code is not 0xF and whose group mask bit is 0 sets a held request, visible in bit g of select 11. Group 0 uses irl_code[3:0] and group 1 uses irl_code[7:4]. Writing 1 to bit g of the group mask-set register (select 3) clears it. Writes to the level-mask registers (select 7 for levels 7..0, select 8 for levels 15..8) leave it set.
- R8: When mode is 1 (select 10 bit 0), level lines and groups are not held: their pending bits follow the live synchronised inputs. Entering mode 1 drops held level requests. Edge requests stay held.
- R9: If a new edge on a line reaches detection in the same cycle as a valid clearing write, the bit stays pending.
- R10: irq_req equals pending AND NOT line mask. irl_req[g] equals group pending AND NOT group mask AND NOT the level-mask bit indexed by the group's held code.
- R11: The register map is as follows. Select 2 writes 1 to unmask lines. Select 4 writes 1 to unmask groups. Select 9 holds the sense bits, where 1 means edge. Selects 5 to 10 read back what was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_pin | input | 8 | Individual request lines, active high |
| irl_code | input | 8 | Two 4-bit encoded-level groups; 0xF means idle |
| reg_rd | input | 1 | Read strobe for the selected register |
| reg_wr | input | 1 | Write strobe for the selected register |
| reg_sel | input | 4 | Register select |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_sel (combinational) |
| irq_req | output | 8 | Pending and unmasked individual requests |
| irl_req | output | 2 | Pending and unmasked group requests |

## Verification
The bench builds the unit with its default eight lines and two synchroniser stages. It sweeps every line through both sensing kinds and runs the full arm-and-release handshake on each. The sweep also includes the write-without-read case and the write-1 case. In pass-through mode, eight lines make all 256 pin patterns cheap to apply. Two 4-bit groups let every code from 0 to 15 be tried on each group, in both held and live handling. The same-cycle set-versus-clear race is placed on an exact clock using the fixed two-stage synchroniser latency.

// File: rtl/irq_hold_pkg.sv
package irq_hold_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_HELD  = 2'd1,
        ST_ARMED = 2'd2
    } line_st_t;

    localparam int SEL_W = 4;

    localparam logic [SEL_W-1:0] SEL_PEND  = 4'd0;
    localparam logic [SEL_W-1:0] SEL_MSET  = 4'd1;
    localparam logic [SEL_W-1:0] SEL_MCLR  = 4'd2;
    localparam logic [SEL_W-1:0] SEL_GSET  = 4'd3;
    localparam logic [SEL_W-1:0] SEL_GCLR  = 4'd4;
    localparam logic [SEL_W-1:0] SEL_PLO   = 4'd5;
    localparam logic [SEL_W-1:0] SEL_PHI   = 4'd6;
    localparam logic [SEL_W-1:0] SEL_LMLO  = 4'd7;
    localparam logic [SEL_W-1:0] SEL_LMHI  = 4'd8;
    localparam logic [SEL_W-1:0] SEL_SENSE = 4'd9;
    localparam logic [SEL_W-1:0] SEL_MODE  = 4'd10;
    localparam logic [SEL_W-1:0] SEL_GPEND = 4'd11;

endpackage

// File: rtl/irq_hold_sync.sv
module irq_hold_sync #(
    parameter int             W       = 8,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stg_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < STAGES; k++) stg_q[k] <= RST_VAL;
        end else begin
            stg_q[0] <= d;
            for (int k = 1; k < STAGES; k++) stg_q[k] <= stg_q[k-1];
        end
    end

    assign q = stg_q[STAGES-1];

endmodule

// File: rtl/irq_line_fsm.sv
module irq_line_fsm
    import irq_hold_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic live,      // synchronised pin
    input  logic sense,     // 1 = edge, 0 = level
    input  logic lvlmode,   // 1 = level requests not held
    input  logic masked,
    input  logic rd_pend,   // read of pending register
    input  logic wr_pend,   // write of pending register
    input  logic wr_bit,    // this line's write data bit
    input  logic mclr_req,  // mask-set write with this bit at 1
    output logic pend
);

    line_st_t st_q, st_d;
    logic     live_d;
    logic     edge_hit, lvl_hit;

    assign edge_hit = sense & live & ~live_d;
    assign lvl_hit  = ~sense & ~lvlmode & live & ~masked;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            live_d <= 1'b0;
        end else begin
            st_q   <= st_d;
            live_d <= live;
        end
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: begin
                if (edge_hit || (lvl_hit && !mclr_req)) st_d = ST_HELD;
            end
            ST_HELD: begin
                if (!sense) begin
                    if (lvlmode || mclr_req) st_d = ST_IDLE;
                end else if (rd_pend) begin
                    st_d = ST_ARMED;
                end
            end
            ST_ARMED: begin
                if (!sense) begin
                    st_d = (lvlmode || mclr_req) ? ST_IDLE : ST_HELD;
                end else if (wr_pend) begin
                    st_d = (!wr_bit && !edge_hit) ? ST_IDLE : ST_HELD;
                end
            end
            default: st_d = ST_IDLE;
        endcase
    end

    always_comb begin
        pend = (lvlmode && !sense) ? live : (st_q != ST_IDLE);
    end

endmodule

// File: rtl/irl_grp_hold.sv
module irl_grp_hold
    import irq_hold_pkg::*;
#(
    parameter int CODE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] code,
    input  logic              lvlmode,
    input  logic              gmasked,
    input  logic              clr_req,
    output logic              pend,
    output logic [CODE_W-1:0] code_out
);

    localparam logic [CODE_W-1:0] IDLE_CODE = '1;

    line_st_t          st_q, st_d;
    logic [CODE_W-1:0] code_q;
    logic              active;

    assign active = (code != IDLE_CODE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            code_q <= IDLE_CODE;
        end else begin
            st_q <= st_d;
            if (st_q == ST_IDLE && st_d == ST_HELD) code_q <= code;
        end
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: begin
                if (active && !lvlmode && !gmasked && !clr_req) st_d = ST_HELD;
            end
            ST_HELD, ST_ARMED: begin
                st_d = (lvlmode || clr_req) ? ST_IDLE : ST_HELD;
            end
            default: st_d = ST_IDLE;
        endcase
    end

    always_comb begin
        pend     = lvlmode ? active : (st_q != ST_IDLE);
        code_out = lvlmode ? code   : code_q;
    end

endmodule

// File: rtl/irq_hold_ctl.sv
module irq_hold_ctl
    import irq_hold_pkg::*;
#(
    parameter int N_IRQ       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_IRQ-1:0] irq_pin,
    input  logic [7:0]       irl_code,
    input  logic             reg_rd,
    input  logic             reg_wr,
    input  logic [SEL_W-1:0] reg_sel,
    input  logic [N_IRQ-1:0] reg_wdata,
    output logic [N_IRQ-1:0] reg_rdata,
    output logic [N_IRQ-1:0] irq_req,
    output logic [1:0]       irl_req
);

    localparam int GRP_W  = 4;
    localparam int N_GRP  = 2;
    localparam int SYNC_W = N_IRQ + N_GRP * GRP_W;
    localparam int DW     = N_IRQ;

    logic [SYNC_W-1:0]        sync_q;
    logic [N_IRQ-1:0]         irq_live;
    logic [N_GRP*GRP_W-1:0]   irl_live;
    logic [N_IRQ-1:0]         pend_view;
    logic [N_GRP-1:0]         irl_pend;
    logic [GRP_W-1:0]         grp_code [N_GRP];

    logic [N_IRQ-1:0]         mask_q, sense_q;
    logic [N_GRP-1:0]         gmask_q;
    logic                     lvlmode_q;
    logic [2*DW-1:0]          prio_q, lvlmask_q;

    logic rd_pend, wr_pend, wr_mset, wr_gset;

    irq_hold_sync #(
        .W       (SYNC_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL ({{(N_GRP*GRP_W){1'b1}}, {N_IRQ{1'b0}}})
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({irl_code, irq_pin}),
        .q     (sync_q)
    );

    assign irq_live = sync_q[N_IRQ-1:0];
    assign irl_live = sync_q[SYNC_W-1:N_IRQ];

    assign rd_pend = reg_rd && (reg_sel == SEL_PEND);
    assign wr_pend = reg_wr && (reg_sel == SEL_PEND);
    assign wr_mset = reg_wr && (reg_sel == SEL_MSET);
    assign wr_gset = reg_wr && (reg_sel == SEL_GSET);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q    <= '1;
            gmask_q   <= '1;
            sense_q   <= '0;
            lvlmode_q <= 1'b0;
            prio_q    <= '0;
            lvlmask_q <= '0;
        end else if (reg_wr) begin
            unique case (reg_sel)
                SEL_MSET:  mask_q            <= mask_q | reg_wdata;
                SEL_MCLR:  mask_q            <= mask_q & ~reg_wdata;
                SEL_GSET:  gmask_q           <= gmask_q | reg_wdata[N_GRP-1:0];
                SEL_GCLR:  gmask_q           <= gmask_q & ~reg_wdata[N_GRP-1:0];
                SEL_PLO:   prio_q[DW-1:0]    <= reg_wdata;
                SEL_PHI:   prio_q[2*DW-1:DW] <= reg_wdata;
                SEL_LMLO:  lvlmask_q[DW-1:0] <= reg_wdata;
                SEL_LMHI:  lvlmask_q[2*DW-1:DW] <= reg_wdata;
                SEL_SENSE: sense_q           <= reg_wdata;
                SEL_MODE:  lvlmode_q         <= reg_wdata[0];
                default: ;
            endcase
        end
    end

    for (genvar i = 0; i < N_IRQ; i++) begin : g_line
        irq_line_fsm u_line (
            .clk      (clk),
            .rst_n    (rst_n),
            .live     (irq_live[i]),
            .sense    (sense_q[i]),
            .lvlmode  (lvlmode_q),
            .masked   (mask_q[i]),
            .rd_pend  (rd_pend),
            .wr_pend  (wr_pend),
            .wr_bit   (reg_wdata[i]),
            .mclr_req (wr_mset && reg_wdata[i]),
            .pend     (pend_view[i])
        );
    end

    for (genvar g = 0; g < N_GRP; g++) begin : g_grp
        irl_grp_hold #(.CODE_W(GRP_W)) u_grp (
            .clk      (clk),
            .rst_n    (rst_n),
            .code     (irl_live[g*GRP_W +: GRP_W]),
            .lvlmode  (lvlmode_q),
            .gmasked  (gmask_q[g]),
            .clr_req  (wr_gset && reg_wdata[g]),
            .pend     (irl_pend[g]),
            .code_out (grp_code[g])
        );
        assign irl_req[g] = irl_pend[g] & ~gmask_q[g] & ~lvlmask_q[grp_code[g]];
    end

    assign irq_req = pend_view & ~mask_q;

    always_comb begin
        reg_rdata = '0;
        case (reg_sel)
            SEL_PEND:            reg_rdata = pend_view;
            SEL_MSET, SEL_MCLR:  reg_rdata = mask_q;
            SEL_GSET, SEL_GCLR:  reg_rdata[N_GRP-1:0] = gmask_q;
            SEL_PLO:             reg_rdata = prio_q[DW-1:0];
            SEL_PHI:             reg_rdata = prio_q[2*DW-1:DW];
            SEL_LMLO:            reg_rdata = lvlmask_q[DW-1:0];
            SEL_LMHI:            reg_rdata = lvlmask_q[2*DW-1:DW];
            SEL_SENSE:           reg_rdata = sense_q;
            SEL_MODE:            reg_rdata[0] = lvlmode_q;
            SEL_GPEND:           reg_rdata[N_GRP-1:0] = irl_pend;
            default:             reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/irq_hold_chk.sv
module irq_hold_chk
    import irq_hold_pkg::*;
#(
    parameter int N_IRQ = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             reg_wr,
    input logic [SEL_W-1:0] reg_sel,
    input logic [N_IRQ-1:0] reg_wdata,
    input logic [N_IRQ-1:0] sense,
    input logic             lvlmode,
    input logic [N_IRQ-1:0] pend,
    input logic [1:0]       irl_pend
);

    for (genvar i = 0; i < N_IRQ; i++) begin : g_chk_line
        // R4: a mask-set write leaves a pending edge request in place
        a_r4_mask_keeps_edge: assert property (@(posedge clk) disable iff (!rst_n)
            (reg_wr && reg_sel == SEL_MSET && reg_wdata[i] && sense[i] && pend[i])
            |=> pend[i]);

        // R5: a mask-set write removes a held level request
        a_r5_mask_clears_level: assert property (@(posedge clk) disable iff (!rst_n)
            (reg_wr && reg_sel == SEL_MSET && reg_wdata[i] && !sense[i] && !lvlmode)
            |=> !pend[i]);

        // R6: priority writes never remove a held level request
        a_r6_prio_keeps_level: assert property (@(posedge clk) disable iff (!rst_n)
            (reg_wr && (reg_sel == SEL_PLO || reg_sel == SEL_PHI) &&
             pend[i] && !sense[i] && !lvlmode)
            |=> pend[i]);
    end

    for (genvar g = 0; g < 2; g++) begin : g_chk_grp
        // R7: group mask-set write removes a held group request
        a_r7_grp_clear: assert property (@(posedge clk) disable iff (!rst_n)
            (reg_wr && reg_sel == SEL_GSET && reg_wdata[g] && !lvlmode)
            |=> !irl_pend[g]);

        // R7: level-mask writes leave a held group request in place
        a_r7_lvlmask_keeps: assert property (@(posedge clk) disable iff (!rst_n)
            (reg_wr && (reg_sel == SEL_LMLO || reg_sel == SEL_LMHI) &&
             irl_pend[g] && !lvlmode)
            |=> irl_pend[g]);
    end

endmodule

bind irq_hold_ctl irq_hold_chk #(.N_IRQ(N_IRQ)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_sel   (reg_sel),
    .reg_wdata (reg_wdata),
    .sense     (sense_q),
    .lvlmode   (lvlmode_q),
    .pend      (pend_view),
    .irl_pend  (irl_pend)
);

// File: tb/irq_hold_ctl_tb_top.sv
module irq_hold_ctl_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] irq_pin = 8'h00;
    logic [7:0] irl_code = 8'hFF;
    logic       reg_rd = 1'b0;
    logic       reg_wr = 1'b0;
    logic [3:0] reg_sel = 4'd0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic [7:0] irq_req;
    logic [1:0] irl_req;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    localparam logic [3:0] A_PEND = 4'd0, A_MSET = 4'd1, A_MCLR = 4'd2,
                           A_GSET = 4'd3, A_GCLR = 4'd4, A_PLO = 4'd5,
                           A_PHI = 4'd6, A_LMLO = 4'd7, A_LMHI = 4'd8,
                           A_SENSE = 4'd9, A_MODE = 4'd10, A_GPEND = 4'd11;

    always #5 clk = ~clk;

    irq_hold_ctl dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_pin   (irq_pin),
        .irl_code  (irl_code),
        .reg_rd    (reg_rd),
        .reg_wr    (reg_wr),
        .reg_sel   (reg_sel),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq_req   (irq_req),
        .irl_req   (irl_req)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] s, input logic [7:0] d);
        @(negedge clk);
        reg_sel = s; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] s, output logic [7:0] d);
        @(negedge clk);
        reg_sel = s; reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(A_PEND, d);  check("R1 pend", d, 8'h00);
        rd(A_MSET, d);  check("R1 mask", d, 8'hFF);
        rd(A_GSET, d);  check("R1 gmask", d, 8'h03);
        rd(A_SENSE, d); check("R1 sense", d, 8'h00);
        rd(A_MODE, d);  check("R1 mode", d, 8'h00);
        rd(A_GPEND, d); check("R1 gpend", d, 8'h00);
        check("R1 irq_req", irq_req, 8'h00);
        check("R1 irl_req", {6'b0, irl_req}, 8'h00);

        // R11 readback
        wr(A_PLO, 8'hA5);  rd(A_PLO, d);  check("R11 prio lo", d, 8'hA5);
        wr(A_PHI, 8'h5A);  rd(A_PHI, d);  check("R11 prio hi", d, 8'h5A);
        wr(A_LMLO, 8'h3C); rd(A_LMLO, d); check("R11 lvlmask lo", d, 8'h3C);
        wr(A_LMHI, 8'hC3); rd(A_LMHI, d); check("R11 lvlmask hi", d, 8'hC3);
        wr(A_LMLO, 8'h00); wr(A_LMHI, 8'h00);
        wr(A_MCLR, 8'hFF); rd(A_MSET, d); check("R11 unmask", d, 8'h00);

        // Edge lines, every line
        wr(A_SENSE, 8'hFF);
        for (int i = 0; i < 8; i++) begin
            logic [7:0] b;
            b = 8'h01 << i;
            irq_pin = b; settle(); irq_pin = 8'h00; settle();
            check("R2 edge sets / R10 req", irq_req, b);
            wr(A_PEND, 8'h00);
            check("R3 write0 without read keeps", irq_req, b);
            wr(A_MSET, b);
            check("R10 masked req", irq_req, 8'h00);
            rd(A_PEND, d); check("R4 mask keeps edge", d, b);
            wr(A_PEND, 8'hFF);
            rd(A_PEND, d); check("R3 write1 keeps", d, b);
            wr(A_PEND, 8'h00);
            rd(A_PEND, d); check("R3 read then write0 clears", d, 8'h00);
            wr(A_MCLR, b);
        end

        // R9 set wins on line 0
        irq_pin = 8'h01; settle(); irq_pin = 8'h00; settle();
        rd(A_PEND, d); check("R9 precondition", d, 8'h01);
        @(negedge clk); irq_pin = 8'h01;
        @(negedge clk);
        @(negedge clk); reg_sel = A_PEND; reg_wdata = 8'h00; reg_wr = 1'b1;
        @(negedge clk); reg_wr = 1'b0;
        settle();
        rd(A_PEND, d); check("R9 set wins", d, 8'h01);
        wr(A_PEND, 8'h00);
        rd(A_PEND, d); check("R9 later clear", d, 8'h00);
        irq_pin = 8'h00; settle();

        // Level lines, every line
        wr(A_SENSE, 8'h00);
        for (int i = 0; i < 8; i++) begin
            logic [7:0] b;
            b = 8'h01 << i;
            irq_pin = b; settle();
            rd(A_PEND, d); check("R5 level sets", d, b);
            irq_pin = 8'h00; settle();
            rd(A_PEND, d); check("R5 level held", d, b);
            wr(A_PEND, 8'h00);
            rd(A_PEND, d); check("R5 pend write no effect", d, b);
            wr(A_PLO, 8'hFF); wr(A_PHI, 8'hFF); wr(A_PLO, 8'h00); wr(A_PHI, 8'h00);
            rd(A_PEND, d); check("R6 prio write keeps", d, b);
            wr(A_MSET, b);
            rd(A_PEND, d); check("R5 mask clears level", d, 8'h00);
            wr(A_MCLR, b);
        end

        // Groups, every non-idle code
        wr(A_GCLR, 8'h03);
        for (int g = 0; g < 2; g++) begin
            for (int c = 0; c < 15; c++) begin
                logic [7:0] gb;
                gb = 8'h01 << g;
                irl_code = (g == 0) ? {4'hF, c[3:0]} : {c[3:0], 4'hF};
                settle();
                rd(A_GPEND, d); check("R7 group sets", d, gb);
                check("R10 irl_req", {6'b0, irl_req}, gb);
                irl_code = 8'hFF; settle();
                rd(A_GPEND, d); check("R7 group held", d, gb);
                wr(A_LMLO, 8'hFF); wr(A_LMHI, 8'hFF);
                check("R10 lvlmask hides", {6'b0, irl_req}, 8'h00);
                rd(A_GPEND, d); check("R7 lvlmask keeps", d, gb);
                wr(A_LMLO, 8'h00); wr(A_LMHI, 8'h00);
                wr(A_GSET, gb);
                rd(A_GPEND, d); check("R7 group clear", d, 8'h00);
                wr(A_GCLR, gb);
            end
        end

        // R8: held level dropped on entering mode 1
        irq_pin = 8'h01; settle(); irq_pin = 8'h00; settle();
        rd(A_PEND, d); check("R8 pre held", d, 8'h01);
        wr(A_MODE, 8'h01);
        rd(A_PEND, d); check("R8 held level dropped", d, 8'h00);

        // R8: live pass-through, all pin patterns
        for (int p = 0; p < 256; p++) begin
            irq_pin = p[7:0]; settle();
            rd(A_PEND, d); check("R8 live level", d, p[7:0]);
            check("R10 live req", irq_req, p[7:0]);
        end
        irq_pin = 8'h00; settle();

        // R8: groups live, all codes
        for (int c = 0; c < 16; c++) begin
            irl_code = {c[3:0], c[3:0]}; settle();
            rd(A_GPEND, d); check("R8 live group", d, (c == 15) ? 8'h00 : 8'h03);
        end
        irl_code = 8'hFF; settle();

        // R8: edge still held in mode 1
        wr(A_SENSE, 8'h08);
        irq_pin = 8'h08; settle(); irq_pin = 8'h00; settle();
        rd(A_PEND, d); check("R8 edge held in mode1", d, 8'h08);
        wr(A_PEND, 8'h00);
        rd(A_PEND, d); check("R3 clear in mode1", d, 8'h00);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule